// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen peripheral lines and presents them to a processor one at a time. The lines are split between two eight-input priority units. The upper unit's combined request takes the place of input 2 of the lower unit. Each line is sampled for a rising edge, and the edge sets a pending bit. A mask can hold back each line on its own. A held-back request stays pending and is delivered once the line is enabled again. When the controller is idle and some unmasked request is pending, the lowest-numbered line wins. Its number is added to a programmable base to form an 8-bit vector. The vector is latched in a register, and the interrupt output goes high.

The interrupt output stays high until the processor writes the acknowledge address. That write clears the served line's pending bit and drops the output for at least one cycle. The controller then serves the next pending line. Software uses a small write port to program the vector base and the two mask bytes, and to issue the acknowledge.

Top module: `pic_cascade_top`

## Requirements
- R1: A request line sets its pending bit only on a rising edge (input low in one cycle, high in the next). A line held high after its acknowledge does not raise another interrupt.
- R2: When several unmasked lines are pending, the winner follows the cascaded order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. The whole upper group sits at the position of lower input 2.
- R3: When idle with an unmasked pending line, intr_o rises in the next cycle. It stays high until a write to address 3 and is low in the cycle after that write. It stays low for at least one cycle before the next interrupt.
- R4: vector_o equals (base + line) modulo 256. It is latched when intr_o rises and does not change while intr_o is high. Address 0 writes the base.
- R5: Address 1 writes the mask for lines 0 to 7 (data bit k masks line k), and address 2 writes the mask for lines 8 to 15 (data bit k masks line 8+k). A 1 masks the line. A masked line keeps its pending bit and is served after it is unmasked.
- R6: Mask bit 2 (address 1, data bit 2) holds back all lines 8 to 15 together.
- R7: Request input 2 is reserved for the cascade and never causes an interrupt.
- R8: An acknowledge write while intr_o is low has no effect, and pending lines stay pending.
- R9: A new request of higher priority that arrives while intr_o is high does not replace the vector being served.
- R10: After a synchronous active-high reset, intr_o and vector_o are 0, all masks are clear, nothing is pending and the base is 32. Line n then maps to vector n+32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 16 | Request lines; bit 2 is reserved |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 base, 1 low mask, 2 high mask, 3 acknowledge |
| wr_data_i | input | 8 | Write data |
| intr_o | output | 1 | Interrupt request to processor |
| vector_o | output | 8 | Latched vector of the line being served |

## Verification
The hardest states to reach are those where the cascade order and the masking meet. One case is an upper-group line pending while a lower line is also pending. Another is an upper-group line held back by mask bit 2 rather than by its own bit. The stimulus pulses line 9 together with line 4 to show the upper group winning at position 2. It also masks bit 2 before pulsing line 12 and then releases the mask. Both cases are compared every cycle against a behavioural model that walks the same priority order. Acknowledges written while idle are checked by masking a line, issuing the stray acknowledge, and then unmasking the line to show that its request survived.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int UNIT_LINES   = 8;
    localparam int TOTAL_LINES  = 2 * UNIT_LINES;
    localparam int CASCADE_PIN  = 2;
    localparam int VEC_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int LINE_W       = $clog2(TOTAL_LINES);
    localparam logic [VEC_W-1:0] DEFAULT_BASE = 8'd32;

    typedef enum logic [ADDR_W-1:0] {
        REG_BASE    = 2'd0,
        REG_MASK_LO = 2'd1,
        REG_MASK_HI = 2'd2,
        REG_ACK     = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } grant_t;

    function automatic logic [VEC_W-1:0] make_vector(
        input logic [VEC_W-1:0]  base,
        input logic [LINE_W-1:0] line
    );
        return base + VEC_W'(line);
    endfunction
endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise;
        assign rise = req_i[g] & ~prev_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= req_i[g];
                pend_q[g] <= (pend_q[g] & ~clr_i[g]) | rise;
            end
        end

        // R1: a pending bit can only appear after a low-to-high step of its input
        a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
            (!pend_q[g] && !(req_i[g] && !prev_q[g])) |=> !pend_q[g]);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pic_prio_unit.sv
module pic_prio_unit #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    // R2: the chosen input is requesting and no lower-numbered input is
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (req_i[idx_o] &&
                     ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int                UNITS_W   = UNIT_LINES,
    parameter int                DATA_W    = VEC_W,
    parameter logic [DATA_W-1:0] BASE_INIT = DEFAULT_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    base_o,
    output logic [2*UNITS_W-1:0] mask_o,
    output logic                 ack_o
);
    logic [DATA_W-1:0]  base_q;
    logic [UNITS_W-1:0] mask_lo_q;
    logic [UNITS_W-1:0] mask_hi_q;
    reg_addr_e          addr;

    assign addr = reg_addr_e'(wr_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= BASE_INIT;
            mask_lo_q <= '0;
            mask_hi_q <= '0;
        end else if (wr_en_i) begin
            case (addr)
                REG_BASE:    base_q    <= wr_data_i;
                REG_MASK_LO: mask_lo_q <= wr_data_i[UNITS_W-1:0];
                REG_MASK_HI: mask_hi_q <= wr_data_i[UNITS_W-1:0];
                default:     ;
            endcase
        end
    end

    assign base_o = base_q;
    assign mask_o = {mask_hi_q, mask_lo_q};
    assign ack_o  = wr_en_i && (addr == REG_ACK);
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
    import pic_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TOTAL_LINES-1:0] irq_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [VEC_W-1:0]       wr_data_i,
    output logic                   intr_o,
    output logic [VEC_W-1:0]       vector_o
);
    localparam int IDX_W = $clog2(UNIT_LINES);

    logic [TOTAL_LINES-1:0] irq_clean, pend, mask, elig, clr;
    logic [VEC_W-1:0]       base;
    logic                   ack_stb;
    logic [UNIT_LINES-1:0]  master_req;
    logic                   slave_valid, master_valid;
    logic [IDX_W-1:0]       slave_idx, master_idx;
    grant_t                 win;
    ctl_state_e             state_q;
    logic [LINE_W-1:0]      served_q;
    logic                   intr_q;
    logic [VEC_W-1:0]       vec_q;

    assign irq_clean = irq_i & ~(TOTAL_LINES'(1) << CASCADE_PIN);

    pic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .base_o    (base),
        .mask_o    (mask),
        .ack_o     (ack_stb)
    );

    pic_edge_capture #(.N(TOTAL_LINES)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .req_i  (irq_clean),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign elig = pend & ~mask;

    pic_prio_unit #(.N(UNIT_LINES)) u_slave (
        .clk     (clk),
        .rst     (rst),
        .req_i   (elig[TOTAL_LINES-1:UNIT_LINES]),
        .valid_o (slave_valid),
        .idx_o   (slave_idx)
    );

    always_comb begin
        master_req              = elig[UNIT_LINES-1:0];
        master_req[CASCADE_PIN] = slave_valid & ~mask[CASCADE_PIN];
    end

    pic_prio_unit #(.N(UNIT_LINES)) u_master (
        .clk     (clk),
        .rst     (rst),
        .req_i   (master_req),
        .valid_o (master_valid),
        .idx_o   (master_idx)
    );

    always_comb begin
        win.valid = master_valid;
        if (master_idx == IDX_W'(CASCADE_PIN))
            win.line = {1'b1, slave_idx};
        else
            win.line = {1'b0, master_idx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            served_q <= '0;
            intr_q   <= 1'b0;
            vec_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (win.valid) begin
                        state_q  <= ST_WAIT_ACK;
                        served_q <= win.line;
                        intr_q   <= 1'b1;
                        vec_q    <= make_vector(base, win.line);
                    end
                end
                ST_WAIT_ACK: begin
                    if (ack_stb) begin
                        state_q <= ST_IDLE;
                        intr_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign clr = (state_q == ST_WAIT_ACK && ack_stb)
                 ? (TOTAL_LINES'(1) << served_q) : '0;

    assign intr_o   = intr_q;
    assign vector_o = vec_q;

    // R3: interrupt held until acknowledged
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (intr_o && !ack_stb) |=> intr_o);
    // R3: acknowledge drops the interrupt in the next cycle
    a_r3_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
        (intr_o && ack_stb) |=> !intr_o);
    // R4: vector frozen while being served
    a_r4_vector_stable: assert property (@(posedge clk) disable iff (rst)
        (intr_o && !ack_stb) |=> $stable(vector_o));
    // R7: the cascade input never becomes pending
    a_r7_cascade_pin_quiet: assert property (@(posedge clk) disable iff (rst)
        !pend[CASCADE_PIN]);
    // R8: a served line only loses its pending bit through an acknowledge
    a_r8_pending_kept: assert property (@(posedge clk) disable iff (rst)
        (intr_o && !ack_stb) |=> pend[served_q]);
endmodule

// File: tb/tb_pic_cascade_top.sv
module tb_pic_cascade_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        intr;
    logic [7:0]  vector;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pic_cascade_top dut (
        .clk(clk), .rst(rst), .irq_i(irq), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .intr_o(intr), .vector_o(vector)
    );

    // behavioural reference
    logic [15:0] m_pend, m_prev, m_mask;
    logic [7:0]  m_base, m_vec;
    bit          m_busy, m_intr;
    int          m_served;

    function automatic int pick(logic [15:0] e, logic cas_masked);
        int order[$];
        order = {0, 1};
        if (!cas_masked) order = {order, 8, 9, 10, 11, 12, 13, 14, 15};
        order = {order, 3, 4, 5, 6, 7};
        foreach (order[k]) if (e[order[k]]) return order[k];
        return -1;
    endfunction

    always @(posedge clk) begin : model
        logic [15:0] nxt;
        int w;
        if (rst) begin
            m_pend = '0; m_prev = '0; m_mask = '0; m_base = 8'd32;
            m_vec = '0; m_busy = 0; m_intr = 0; m_served = 0;
        end else begin
            nxt = m_pend;
            if (m_busy) begin
                if (wr_en && wr_addr == 2'd3) begin
                    nxt[m_served] = 1'b0; m_busy = 0; m_intr = 0;
                end
            end else begin
                w = pick(m_pend & ~m_mask, m_mask[2]);
                if (w >= 0) begin
                    m_busy = 1; m_intr = 1; m_served = w;
                    m_vec = 8'(m_base + 8'(w));
                end
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) m_base = wr_data;
                if (wr_addr == 2'd1) m_mask[7:0] = wr_data;
                if (wr_addr == 2'd2) m_mask[15:8] = wr_data;
            end
            for (int n = 0; n < 16; n++)
                if (n != 2 && irq[n] && !m_prev[n]) nxt[n] = 1'b1;
            m_prev = irq;
            m_pend = nxt;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (intr !== m_intr) begin
                fails++;
                $display("FAIL R3 model intr actual=%0b expected=%0b", intr, m_intr);
            end
            checks++;
            if (vector !== m_vec) begin
                fails++;
                $display("FAIL R4 model vector actual=%0d expected=%0d", vector, m_vec);
            end
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int l);
        @(negedge clk); irq[l] = 1'b1;
        @(negedge clk); irq[l] = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack();
        wr(2'd3, 8'd0);
    endtask

    task automatic expect_irq(string tag, logic [7:0] v);
        chk({tag, " intr"}, 8'(intr), 8'd1);
        chk({tag, " vector"}, vector, v);
    endtask

    initial begin
        fork
            begin
                tick(3);
                rst = 1'b0;
                chk("R10 reset intr", 8'(intr), 8'd0);
                chk("R10 reset vector", vector, 8'd0);

                pulse(5); tick(1); expect_irq("R10 default base line5", 8'd37);
                ack(); chk("R3 drop after ack", 8'(intr), 8'd0);

                @(negedge clk); irq[1] = 1; irq[3] = 1;
                @(negedge clk); irq[1] = 0; irq[3] = 0;
                tick(1); expect_irq("R2 line1 over 3", 8'd33);
                ack(); chk("R3 gap low", 8'(intr), 8'd0);
                tick(1); expect_irq("R3 next served line3", 8'd35);
                ack();

                @(negedge clk); irq[9] = 1; irq[4] = 1;
                @(negedge clk); irq[9] = 0; irq[4] = 0;
                tick(1); expect_irq("R2 cascade 9 over 4", 8'd41);
                ack(); tick(1); expect_irq("R2 then line4", 8'd36);
                ack();

                wr(2'd1, 8'h40); pulse(6); tick(3);
                chk("R5 masked line6 silent", 8'(intr), 8'd0);
                wr(2'd1, 8'h00); tick(1); expect_irq("R5 line6 after unmask", 8'd38);
                ack();

                wr(2'd2, 8'h20); pulse(13); tick(3);
                chk("R5 masked line13 silent", 8'(intr), 8'd0);
                wr(2'd2, 8'h00); tick(1); expect_irq("R5 line13 after unmask", 8'd45);
                ack();

                wr(2'd1, 8'h04); pulse(12); tick(3);
                chk("R6 cascade mask holds line12", 8'(intr), 8'd0);
                wr(2'd1, 8'h00); tick(1); expect_irq("R6 line12 released", 8'd44);
                ack();

                pulse(2); tick(3);
                chk("R7 reserved input ignored", 8'(intr), 8'd0);

                wr(2'd2, 8'h08); pulse(11); ack();
                wr(2'd2, 8'h00); tick(1); expect_irq("R8 idle ack ignored", 8'd43);
                ack();

                wr(2'd0, 8'hF8); pulse(15); tick(1); expect_irq("R4 base wrap", 8'd7);
                ack(); wr(2'd0, 8'd32);

                @(negedge clk); irq[10] = 1;
                tick(2); expect_irq("R1 level line10", 8'd42);
                ack(); tick(3);
                chk("R1 held level no retrigger", 8'(intr), 8'd0);
                irq[10] = 0;

                pulse(7); tick(1); expect_irq("R9 line7 served", 8'd39);
                pulse(0); tick(2); expect_irq("R9 no preempt", 8'd39);
                ack(); tick(1); expect_irq("R9 line0 after ack", 8'd32);
                ack(); tick(2);
            end
            begin
                tick(20000);
                fails++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule